// File: doc/BRIEF.md
# Disk Rotational Position and Start-Latency Timer

This block tracks where a head-per-track disk is in its rotation, as a word index that counts upward and wraps after 2048 words. The index steps forward once every "interword time" clock cycles, a programmable non-zero value that comes out of reset at 10. Software can read the index at any time as a status word that also shows whether a start countdown is under way.

When the controller issues a start with any function other than no-op, the block works out how many words must pass before the addressed word reaches the heads. It multiplies that count by the interword time and counts the result down. When the countdown ends, it pulses a one-cycle start strobe to the transfer engine. A controller reset abandons any countdown but leaves the rotation running.

Top module: `rot_latency_timer`

## Requirements
- R1: After `rst_n` is low, the position is 0, `busy` and `start_strobe` are low, `pos_status` is 0 and `iwt_cur` is 10.
- R2: The position rises by exactly one every `iwt_cur` clock cycles and wraps from 2047 to 0.
- R3: A write (`iwt_wr` high) of a non-zero value sets `iwt_cur` from the next cycle on. A write of zero is ignored and the previous value is kept.
- R4: A start with `start_func` not 00, sampled while idle, gives a delay D = ((`start_word` − position) mod 2048) × `iwt_cur`, using the values held in the command cycle. For D > 0, `busy` is high for exactly D cycles after the command edge. `start_strobe` is then high for one cycle, the cycle after the D-th edge.
- R5: When the target word equals the current position (D = 0), `start_strobe` is high in the cycle right after the command edge, and `busy` stays low.
- R6: A start with `start_func` = 00 (no-op) neither raises `busy` nor produces a strobe.
- R7: A start command that arrives while `busy` is high is ignored. The running countdown and its strobe time are not changed.
- R8: `ctl_reset` clears `busy` on the next edge and suppresses the strobe, even in the cycle where the countdown would have expired. It does not disturb the position or `iwt_cur`, and it takes priority over a start in the same cycle.
- R9: `pos_status` carries the position in bits 10:0 and `busy` in bit 17, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_reset | input | 1 | Controller reset: cancels a countdown |
| iwt_wr | input | 1 | Interword-time write enable |
| iwt_wdata | input | 16 | Interword time, in clocks per word |
| start_cmd | input | 1 | Start command |
| start_func | input | 2 | Function code, 00 = no-op |
| start_word | input | 11 | Target word within the track |
| start_strobe | output | 1 | One-cycle pulse when the target word arrives |
| busy | output | 1 | Countdown in progress |
| iwt_cur | output | 16 | Interword time in use |
| pos_status | output | 18 | Position-read word {busy, zeros, position} |

## Verification
Expiry of a countdown can fall in the same cycle as a controller reset, and in the same cycle as a fresh start command. The bench provokes both on purpose: it asserts `ctl_reset` exactly on the last busy cycle of a short countdown, and it issues starts while `busy` is still high. It also makes random starts, interword-time writes and resets coincide. A cycle model built from the requirements judges each of these cases. It expects the reset to win with no strobe, the late start to be dropped, and a start that shares a cycle with an interword-time write to use the old interword time.

// File: rtl/rotpos_pkg.sv
package rotpos_pkg;
    typedef enum logic [1:0] {
        FUNC_NONE    = 2'd0,
        FUNC_FETCH   = 2'd1,
        FUNC_STORE   = 2'd2,
        FUNC_COMPARE = 2'd3
    } rot_func_e;
endpackage

// File: rtl/rotpos_angle_counter.sv
module rotpos_angle_counter #(
    parameter int WORD_W  = 11,
    parameter int IWT_W   = 16,
    parameter int IWT_RST = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iwt_wr,
    input  logic [IWT_W-1:0]  iwt_wdata,
    output logic [WORD_W-1:0] pos,
    output logic [IWT_W-1:0]  iwt
);
    typedef struct packed {
        logic [IWT_W-1:0]  tick;
        logic [WORD_W-1:0] pos;
        logic [IWT_W-1:0]  iwt;
    } angle_t;

    angle_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (state_q.tick >= state_q.iwt - IWT_W'(1)) begin
            state_d.tick = '0;
            state_d.pos  = state_q.pos + WORD_W'(1);
        end else begin
            state_d.tick = state_q.tick + IWT_W'(1);
        end
        if (iwt_wr && (iwt_wdata != '0)) begin
            state_d.iwt = iwt_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.tick <= '0;
            state_q.pos  <= '0;
            state_q.iwt  <= IWT_W'(IWT_RST);
        end else begin
            state_q <= state_d;
        end
    end

    assign pos = state_q.pos;
    assign iwt = state_q.iwt;
endmodule

// File: rtl/rotpos_latency_calc.sv
module rotpos_latency_calc #(
    parameter int WORD_W = 11,
    parameter int IWT_W  = 16,
    localparam int DLY_W = WORD_W + IWT_W
) (
    input  logic [WORD_W-1:0] cur_pos,
    input  logic [WORD_W-1:0] target,
    input  logic [IWT_W-1:0]  iwt,
    output logic [DLY_W-1:0]  delay,
    output logic              delay_zero
);
    logic [WORD_W-1:0] word_gap;

    always_comb begin
        word_gap   = target - cur_pos;
        delay      = DLY_W'(word_gap) * DLY_W'(iwt);
        delay_zero = (word_gap == '0);
    end
endmodule

// File: rtl/rotpos_start_timer.sv
module rotpos_start_timer #(
    parameter int DLY_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_reset,
    input  logic             launch,
    input  logic [DLY_W-1:0] delay,
    input  logic             delay_zero,
    output logic             busy,
    output logic             strobe
);
    typedef struct packed {
        logic [DLY_W-1:0] cnt;
        logic             busy;
        logic             strobe;
    } timer_t;

    timer_t tmr_d, tmr_q;

    always_comb begin
        tmr_d        = tmr_q;
        tmr_d.strobe = 1'b0;
        if (ctl_reset) begin
            tmr_d.busy = 1'b0;
            tmr_d.cnt  = '0;
        end else if (tmr_q.busy) begin
            if (tmr_q.cnt == DLY_W'(1)) begin
                tmr_d.busy   = 1'b0;
                tmr_d.cnt    = '0;
                tmr_d.strobe = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt - DLY_W'(1);
            end
        end else if (launch) begin
            if (delay_zero) begin
                tmr_d.strobe = 1'b1;
            end else begin
                tmr_d.busy = 1'b1;
                tmr_d.cnt  = delay;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy   = tmr_q.busy;
    assign strobe = tmr_q.strobe;
endmodule

// File: rtl/rot_latency_timer.sv
module rot_latency_timer #(
    parameter int WORD_W  = 11,
    parameter int IWT_W   = 16,
    parameter int IWT_RST = 10,
    parameter int STAT_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_reset,
    input  logic              iwt_wr,
    input  logic [IWT_W-1:0]  iwt_wdata,
    input  logic              start_cmd,
    input  logic [1:0]        start_func,
    input  logic [WORD_W-1:0] start_word,
    output logic              start_strobe,
    output logic              busy,
    output logic [IWT_W-1:0]  iwt_cur,
    output logic [STAT_W-1:0] pos_status
);
    import rotpos_pkg::*;

    localparam int DLY_W = WORD_W + IWT_W;

    logic [WORD_W-1:0] cur_pos;
    logic [DLY_W-1:0]  delay;
    logic              delay_zero;
    logic              launch;
    rot_func_e         func;

    rotpos_angle_counter #(
        .WORD_W (WORD_W),
        .IWT_W  (IWT_W),
        .IWT_RST(IWT_RST)
    ) u_angle (
        .clk      (clk),
        .rst_n    (rst_n),
        .iwt_wr   (iwt_wr),
        .iwt_wdata(iwt_wdata),
        .pos      (cur_pos),
        .iwt      (iwt_cur)
    );

    rotpos_latency_calc #(
        .WORD_W(WORD_W),
        .IWT_W (IWT_W)
    ) u_calc (
        .cur_pos   (cur_pos),
        .target    (start_word),
        .iwt       (iwt_cur),
        .delay     (delay),
        .delay_zero(delay_zero)
    );

    always_comb begin
        func   = rot_func_e'(start_func);
        launch = start_cmd && (func != FUNC_NONE);
    end

    rotpos_start_timer #(
        .DLY_W(DLY_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_reset (ctl_reset),
        .launch    (launch),
        .delay     (delay),
        .delay_zero(delay_zero),
        .busy      (busy),
        .strobe    (start_strobe)
    );

    generate
        if (STAT_W > WORD_W + 1) begin : g_pad
            assign pos_status = {busy, {(STAT_W-WORD_W-1){1'b0}}, cur_pos};
        end else begin : g_tight
            assign pos_status = {busy, cur_pos};
        end
    endgenerate
endmodule

// File: rtl/rot_latency_timer_chk.sv
module rot_latency_timer_chk #(
    parameter int WORD_W = 11,
    parameter int IWT_W  = 16,
    parameter int STAT_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_reset,
    input logic              iwt_wr,
    input logic [IWT_W-1:0]  iwt_wdata,
    input logic              start_cmd,
    input logic [1:0]        start_func,
    input logic              start_strobe,
    input logic              busy,
    input logic [IWT_W-1:0]  iwt_cur,
    input logic [STAT_W-1:0] pos_status
);
    logic [WORD_W-1:0] pos_view;
    assign pos_view = pos_status[WORD_W-1:0];

    AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_view != $past(pos_view)) |-> (pos_view == $past(pos_view) + WORD_W'(1))); // R2

    AST_IWT_ZERO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (iwt_wr && (iwt_wdata == '0)) |=> $stable(iwt_cur)); // R3

    AST_IWT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        iwt_cur != '0); // R3

    AST_EXPIRY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(ctl_reset)) |-> start_strobe); // R4

    AST_NOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cmd && (start_func == 2'b00) && !busy && !ctl_reset) |=> (!busy && !start_strobe)); // R6

    AST_CTL_RESET_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_reset |=> (!busy && !start_strobe)); // R8

    AST_STATUS_BUSY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        pos_status[STAT_W-1] == busy); // R9
endmodule

bind rot_latency_timer rot_latency_timer_chk #(
    .WORD_W(WORD_W),
    .IWT_W (IWT_W),
    .STAT_W(STAT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_reset   (ctl_reset),
    .iwt_wr      (iwt_wr),
    .iwt_wdata   (iwt_wdata),
    .start_cmd   (start_cmd),
    .start_func  (start_func),
    .start_strobe(start_strobe),
    .busy        (busy),
    .iwt_cur     (iwt_cur),
    .pos_status  (pos_status)
);

// File: tb/rot_latency_timer_tb.sv
module rot_latency_timer_tb;
    localparam int WORDS = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_reset = 1'b0;
    logic        iwt_wr = 1'b0;
    logic [15:0] iwt_wdata = '0;
    logic        start_cmd = 1'b0;
    logic [1:0]  start_func = '0;
    logic [10:0] start_word = '0;
    logic        start_strobe;
    logic        busy;
    logic [15:0] iwt_cur;
    logic [17:0] pos_status;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rot_latency_timer u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_reset(ctl_reset),
        .iwt_wr(iwt_wr), .iwt_wdata(iwt_wdata),
        .start_cmd(start_cmd), .start_func(start_func), .start_word(start_word),
        .start_strobe(start_strobe), .busy(busy), .iwt_cur(iwt_cur),
        .pos_status(pos_status)
    );

    // Reference model, written from the requirements
    int m_pos, m_tick, m_iwt, m_cnt;
    bit m_busy, m_strobe;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pos = 0; m_tick = 0; m_iwt = 10; m_cnt = 0; m_busy = 0; m_strobe = 0;
        end else begin
            int n_pos, n_tick, n_iwt, n_cnt, d;
            bit n_busy, n_strobe;
            n_pos = m_pos; n_iwt = m_iwt; n_cnt = m_cnt; n_busy = m_busy; n_strobe = 0;
            if (m_tick + 1 >= m_iwt) begin
                n_tick = 0; n_pos = (m_pos + 1) % WORDS;
            end else n_tick = m_tick + 1;
            if (iwt_wr && iwt_wdata != 0) n_iwt = iwt_wdata;
            if (ctl_reset) begin
                n_busy = 0; n_cnt = 0;
            end else if (m_busy) begin
                if (m_cnt == 1) begin n_busy = 0; n_cnt = 0; n_strobe = 1; end
                else n_cnt = m_cnt - 1;
            end else if (start_cmd && start_func != 2'b00) begin
                d = ((int'(start_word) - m_pos + WORDS) % WORDS) * m_iwt;
                if (d == 0) n_strobe = 1;
                else begin n_busy = 1; n_cnt = d; end
            end
            m_pos = n_pos; m_tick = n_tick; m_iwt = n_iwt; m_cnt = n_cnt;
            m_busy = n_busy; m_strobe = n_strobe;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    bit model_cmp = 0;
    always @(negedge clk) begin
        if (model_cmp && rst_n) begin
            chk("R2 position", pos_status[10:0], m_pos);
            chk("R4 busy", busy, m_busy);
            chk("R4 strobe", start_strobe, m_strobe);
            chk("R3 interword time", iwt_cur, m_iwt);
            chk("R9 status", pos_status, {m_busy, 6'b0, 11'(m_pos)});
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        ctl_reset = 0; iwt_wr = 0; iwt_wdata = 0; start_cmd = 0; start_func = 0;
    endtask

    task automatic set_iwt(input int v);
        iwt_wr = 1; iwt_wdata = 16'(v); step(); idle_inputs();
    endtask

    // issue a start aimed gap words ahead; return cycles until the strobe
    task automatic timed_start(input int gap, input int limit, output int seen);
        int p;
        p = pos_status[10:0];
        start_cmd = 1; start_func = 2'b01; start_word = 11'((p + gap) % WORDS);
        step(); idle_inputs();
        seen = -1;
        for (int k = 1; k <= limit; k++) begin
            if (start_strobe) begin seen = k; break; end
            step();
        end
    endtask

    initial begin
        #(10 * 195000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seen, p, iw;
        void'($urandom(32'h5eed_0042));
        repeat (3) step();
        rst_n = 1;
        step();
        // R1 reset state
        chk("R1 status", pos_status, 0);
        chk("R1 busy", busy, 0);
        chk("R1 strobe", start_strobe, 0);
        chk("R1 iwt", iwt_cur, 10);
        model_cmp = 1;

        // R2 position cadence at default interword time
        p = pos_status[10:0];
        repeat (100) step();
        chk("R2 ten words per hundred cycles", (int'(pos_status[10:0]) - p + WORDS) % WORDS, 10);

        // R3 zero write ignored, non-zero write taken
        set_iwt(0);
        chk("R3 zero write ignored", iwt_cur, 10);
        set_iwt(3);
        chk("R3 write taken", iwt_cur, 3);

        // R5 zero delay
        p = pos_status[10:0];
        start_cmd = 1; start_func = 2'b10; start_word = 11'(p);
        step(); idle_inputs();
        chk("R5 immediate strobe", start_strobe, 1);
        chk("R5 busy stays low", busy, 0);

        // R6 no-op
        p = pos_status[10:0];
        start_cmd = 1; start_func = 2'b00; start_word = 11'(p + 7);
        step(); idle_inputs();
        chk("R6 no busy", busy, 0);
        repeat (30) begin
            step();
            if (start_strobe) break;
        end
        chk("R6 no strobe", start_strobe, 0);

        // R4 exact timing: 5 words at iwt 3 => strobe at 16th negedge
        timed_start(5, 100, seen);
        chk("R4 strobe timing", seen, 16);

        // R7 start while busy is ignored
        p = pos_status[10:0];
        start_cmd = 1; start_func = 2'b11; start_word = 11'((p + 4) % WORDS);
        step();
        start_word = 11'((p + 1) % WORDS);
        step(); idle_inputs();
        seen = -1;
        for (int k = 2; k <= 40; k++) begin
            if (start_strobe) begin seen = k; break; end
            step();
        end
        chk("R7 late start ignored", seen, 13);

        // R4 wrap: target one word behind, iwt 1 => 2047 cycles
        set_iwt(1);
        timed_start(WORDS - 1, 2100, seen);
        chk("R4 wrapped delay", seen, 2048);

        // R8 cancel mid countdown, position undisturbed
        set_iwt(2);
        p = pos_status[10:0];
        start_cmd = 1; start_func = 2'b01; start_word = 11'((p + 40) % WORDS);
        step(); idle_inputs();
        repeat (5) step();
        ctl_reset = 1; step(); idle_inputs();
        chk("R8 busy cleared", busy, 0);
        chk("R8 iwt kept", iwt_cur, 2);
        seen = 0;
        repeat (100) begin step(); if (start_strobe) seen = 1; end
        chk("R8 no strobe after cancel", seen, 0);

        // R8 reset on the expiry cycle, with a start alongside
        p = pos_status[10:0];
        start_cmd = 1; start_func = 2'b01; start_word = 11'((p + 10) % WORDS);
        step(); idle_inputs();
        repeat (19) step();
        chk("R8 last busy cycle", busy, 1);
        ctl_reset = 1; start_cmd = 1; start_func = 2'b01; start_word = 11'(pos_status[10:0]);
        step(); idle_inputs();
        chk("R8 reset beats expiry", start_strobe, 0);
        chk("R8 reset beats start", busy, 0);

        // random mix
        for (int i = 0; i < 40000; i++) begin
            idle_inputs();
            if ($urandom_range(0, 99) < 4) begin
                iwt_wr = 1; iwt_wdata = 16'($urandom_range(0, 4));
            end
            if ($urandom_range(0, 99) < 3) begin
                start_cmd = 1; start_func = 2'($urandom_range(0, 3));
                start_word = 11'($urandom_range(0, WORDS - 1));
                if ($urandom_range(0, 3) == 0) start_word = pos_status[10:0];
            end
            if ($urandom_range(0, 999) < 2) ctl_reset = 1;
            step();
        end
        idle_inputs();
        iw = 0;
        step();
        chk("R1 final sanity iwt nonzero", (iwt_cur != 0), 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule